// File: doc/BRIEF.md
# Flag-Producing 8-bit Arithmetic and Logic Unit

This block is the arithmetic and logic stage of a small processor core. Each cycle in which the write-enable is high, it takes two operands and an opcode and computes the result. The result goes into an output register, and the condition flags go into a status register. The operations are add, subtract, compare, AND, OR, increment, decrement, clear and two's-complement negate.

The status register holds six condition flags:
- carry/borrow;
- zero;
- negative;
- two's-complement overflow;
- a signed-sign flag, equal to negative XOR overflow;
- a nibble half-carry.

It also holds an interrupt-enable bit that ALU operations never alter. Each operation updates only the flags it defines. The flags it does not define keep their earlier values. Compare sets the flags as subtract does but leaves the result register alone.

A combinational branch evaluator reads the stored flags. From a 3-bit condition selector it reports whether a branch would be taken. Signed tests use the sign flag. Unsigned tests use carry alone.

Top module: `flag_alu`

## Requirements
- R1: After reset, result is 0 and status is {IE_RESET, 0, H, S, V, N, Z, C} with all six flags 0. The status bit positions are: C bit 0, Z bit 1, N bit 2, V bit 3, S bit 4, H bit 5, bit 6 always 0, interrupt-enable bit 7.
- R2: ADD (opcode 0) writes a+b. C is set to the carry out of bit 7 (0xFF+0x01 sets C). H is set to the carry out of bit 3 (0x0A+0x06 sets H; 0x4A+0x24 clears it).
- R3: SUB (opcode 1) writes a-b. C is set to the borrow out of bit 7, which is 1 exactly when a<b unsigned. H is set to the borrow into bit 4, which is 1 exactly when a[3:0]<b[3:0].
- R4: On ADD and SUB, V is set to signed overflow. 0x40+0x40 sets V, and 0x80-0x01 sets V.
- R5: Every opcode that updates N, Z and S sets them as follows: N is bit 7 of the computed value, Z is 1 when the computed value is zero, and S is N XOR V. So 0x40+0x40 gives N=1, V=1, S=0.
- R6: CMP (opcode 2) updates C, Z, N, V, S and H exactly as SUB does, and leaves the result register unchanged.
- R7: AND (opcode 3) and OR (opcode 4) write the bitwise result, clear V, and update N, Z and S. C and H are left unchanged.
- R8: INC (opcode 5) writes a+1 and sets V only when a=0x7F. DEC (opcode 6) writes a-1 and sets V only when a=0x80. Both update N, Z and S and leave C and H unchanged.
- R9: CLR (opcode 7) writes 0, sets Z and clears N, V and S. C and H are left unchanged.
- R10: NEG (opcode 8) writes 0-a. C is 1 when the result is nonzero, H is 1 when a[3:0] is nonzero, and V is 1 only when a=0x80.
- R11: When op_valid is low, or the opcode is 9 to 15, neither the result nor the status changes.
- R12: The interrupt-enable bit (status bit 7) never changes after reset.
- R13: branch_taken is computed from the stored status for each value of br_sel:

  | br_sel | branch_taken |
  |---|---|
  | 0 | Z |
  | 1 | !Z |
  | 2 | C (unsigned lower) |
  | 3 | !C (unsigned same-or-higher) |
  | 4 | S (signed less) |
  | 5 | !S (signed greater-or-equal) |
  | 6 | N |
  | 7 | V |

  N and V by themselves do not affect the signed tests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Write-enable: perform the opcode this cycle |
| opcode | input | 4 | Operation select |
| opnd_a | input | DATA_W | First operand (sole operand of unary operations) |
| opnd_b | input | DATA_W | Second operand |
| br_sel | input | 3 | Branch condition select |
| result | output | DATA_W | Registered result |
| status | output | 8 | Registered status: {IE, 0, H, S, V, N, Z, C} |
| branch_taken | output | 1 | Chosen condition evaluated on the stored status |

## Verification
The checker assumes that, outside reset, opcode, operands and op_valid are known values at every rising edge. Several properties also compare against operands sampled one cycle earlier, so they assume operands are held stable through the edge where an operation is captured.

The bench drives every input on the falling edge and holds it across the capturing edge. It drives op_valid low between operations and places undefined opcodes only under op_valid. As a result, every sampled value is defined and the idle-cycle properties see genuinely idle inputs.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   localparam int STATUS_W = 8;
   localparam int FLAG_N   = 6;

   localparam int FB_C  = 0;
   localparam int FB_Z  = 1;
   localparam int FB_N  = 2;
   localparam int FB_V  = 3;
   localparam int FB_S  = 4;
   localparam int FB_H  = 5;
   localparam int FB_IE = 7;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_CMP = 4'd2,
      OP_AND = 4'd3,
      OP_OR  = 4'd4,
      OP_INC = 4'd5,
      OP_DEC = 4'd6,
      OP_CLR = 4'd7,
      OP_NEG = 4'd8
   } alu_op_e;

   typedef enum logic [2:0] {
      BR_ZS  = 3'd0,
      BR_ZC  = 3'd1,
      BR_LO  = 3'd2,
      BR_SH  = 3'd3,
      BR_LT  = 3'd4,
      BR_GE  = 3'd5,
      BR_MI  = 3'd6,
      BR_VS  = 3'd7
   } br_cond_e;

endpackage

// File: rtl/flag_alu_core.sv
module flag_alu_core
   import flag_alu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int HALF_POS = 4
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] res,
   output logic              wr_res,
   output logic [FLAG_N-1:0] flag_nxt,
   output logic [FLAG_N-1:0] flag_upd
);

   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] sub_x, sub_y;
   logic [DATA_W:0]   add_w, sub_w;
   logic [HALF_POS:0] add_lo, sub_lo;
   logic              is_neg;

   // shared adder and subtractor; negate reuses the subtractor as 0 - a
   assign is_neg = (op == OP_NEG);
   assign sub_x  = is_neg ? '0 : a;
   assign sub_y  = is_neg ? a  : b;
   assign add_w  = {1'b0, a} + {1'b0, b};
   assign sub_w  = {1'b0, sub_x} - {1'b0, sub_y};
   assign add_lo = {1'b0, a[HALF_POS-1:0]} + {1'b0, b[HALF_POS-1:0]};
   assign sub_lo = {1'b0, sub_x[HALF_POS-1:0]} - {1'b0, sub_y[HALF_POS-1:0]};

   logic c_v, h_v, v_v, n_v, z_v;

   always_comb begin
      res      = '0;
      wr_res   = 1'b0;
      c_v      = 1'b0;
      h_v      = 1'b0;
      v_v      = 1'b0;
      flag_upd = '0;
      unique case (op)
         OP_ADD: begin
            res    = add_w[MSB:0];
            wr_res = 1'b1;
            c_v    = add_w[DATA_W];
            h_v    = add_lo[HALF_POS];
            v_v    = (a[MSB] == b[MSB]) && (add_w[MSB] != a[MSB]);
            flag_upd = '1;
         end
         OP_SUB, OP_CMP, OP_NEG: begin
            res    = sub_w[MSB:0];
            wr_res = (op != OP_CMP);
            c_v    = sub_w[DATA_W];
            h_v    = sub_lo[HALF_POS];
            v_v    = (sub_x[MSB] != sub_y[MSB]) && (sub_w[MSB] != sub_x[MSB]);
            flag_upd = '1;
         end
         OP_AND, OP_OR: begin
            res    = (op == OP_AND) ? (a & b) : (a | b);
            wr_res = 1'b1;
            flag_upd[FB_Z] = 1'b1;
            flag_upd[FB_N] = 1'b1;
            flag_upd[FB_V] = 1'b1;
            flag_upd[FB_S] = 1'b1;
         end
         OP_INC, OP_DEC: begin
            res    = (op == OP_INC) ? (a + 1'b1) : (a - 1'b1);
            wr_res = 1'b1;
            v_v    = (op == OP_INC) ? (a == (MIN_NEG - 1'b1)) : (a == MIN_NEG);
            flag_upd[FB_Z] = 1'b1;
            flag_upd[FB_N] = 1'b1;
            flag_upd[FB_V] = 1'b1;
            flag_upd[FB_S] = 1'b1;
         end
         OP_CLR: begin
            res    = '0;
            wr_res = 1'b1;
            flag_upd[FB_Z] = 1'b1;
            flag_upd[FB_N] = 1'b1;
            flag_upd[FB_V] = 1'b1;
            flag_upd[FB_S] = 1'b1;
         end
         default: begin
            res    = '0;
            wr_res = 1'b0;
         end
      endcase
   end

   assign n_v = res[MSB];
   assign z_v = (res == '0);

   always_comb begin
      flag_nxt       = '0;
      flag_nxt[FB_C] = c_v;
      flag_nxt[FB_Z] = z_v;
      flag_nxt[FB_N] = n_v;
      flag_nxt[FB_V] = v_v;
      flag_nxt[FB_S] = n_v ^ v_v;
      flag_nxt[FB_H] = h_v;
   end

endmodule

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
   import flag_alu_pkg::*;
(
   input  logic [STATUS_W-1:0] st,
   input  logic [2:0]          sel,
   output logic                taken
);

   always_comb begin
      unique case (br_cond_e'(sel))
         BR_ZS:   taken =  st[FB_Z];
         BR_ZC:   taken = !st[FB_Z];
         BR_LO:   taken =  st[FB_C];
         BR_SH:   taken = !st[FB_C];
         BR_LT:   taken =  st[FB_S];
         BR_GE:   taken = !st[FB_S];
         BR_MI:   taken =  st[FB_N];
         BR_VS:   taken =  st[FB_V];
         default: taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int   DATA_W   = 8,
   parameter int   HALF_POS = 4,
   parameter logic IE_RESET = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic [3:0]          opcode,
   input  logic [DATA_W-1:0]   opnd_a,
   input  logic [DATA_W-1:0]   opnd_b,
   input  logic [2:0]          br_sel,
   output logic [DATA_W-1:0]   result,
   output logic [STATUS_W-1:0] status,
   output logic                branch_taken
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("flag_alu: DATA_W must be at least 2");
      end
      if (HALF_POS < 1 || HALF_POS >= DATA_W) begin : g_bad_half
         $error("flag_alu: HALF_POS must lie inside the data word");
      end
   endgenerate

   logic [DATA_W-1:0] res_c;
   logic              wr_c;
   logic [FLAG_N-1:0] nxt_c, upd_c;
   logic [FLAG_N-1:0] flag_q;
   logic              ie_q;

   flag_alu_core #(
      .DATA_W   (DATA_W),
      .HALF_POS (HALF_POS)
   ) u_core (
      .op       (opcode),
      .a        (opnd_a),
      .b        (opnd_b),
      .res      (res_c),
      .wr_res   (wr_c),
      .flag_nxt (nxt_c),
      .flag_upd (upd_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
      end else if (op_valid && wr_c) begin
         result <= res_c;
      end
   end

   // each flag register loads only when the operation defines it
   generate
      for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q[gi] <= 1'b0;
            end else if (op_valid && upd_c[gi]) begin
               flag_q[gi] <= nxt_c[gi];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= IE_RESET;
      end else begin
         ie_q <= ie_q;
      end
   end

   assign status = {ie_q, 1'b0, flag_q};

   flag_alu_cond u_cond (
      .st    (status),
      .sel   (br_sel),
      .taken (branch_taken)
   );

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
   import flag_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                op_valid,
   input logic [3:0]          opcode,
   input logic [DATA_W-1:0]   opnd_a,
   input logic [DATA_W-1:0]   opnd_b,
   input logic [2:0]          br_sel,
   input logic [DATA_W-1:0]   result,
   input logic [STATUS_W-1:0] status,
   input logic                branch_taken
);

   logic [DATA_W:0] sum_w;
   logic            writes;
   assign sum_w  = {1'b0, opnd_a} + {1'b0, opnd_b};
   assign writes = op_valid && (opcode <= 4'd8) && (opcode != 4'd2);

   p_ie_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(status[FB_IE]));

   p_sign_xor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      status[FB_S] == (status[FB_N] ^ status[FB_V]));

   p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      writes |=> status[FB_Z] == (result == '0));

   p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode == 4'd0) |=> status[FB_C] == $past(sum_w[DATA_W]));

   p_sub_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (opcode == 4'd1 || opcode == 4'd2)) |=>
         status[FB_C] == $past(opnd_a < opnd_b));

   p_cmp_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode == 4'd2) |=> $stable(result));

   p_logic_vclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (opcode == 4'd3 || opcode == 4'd4)) |=>
         !status[FB_V] && $stable(status[FB_C]) && $stable(status[FB_H]));

   p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode == 4'd7) |=> (result == '0) && status[FB_Z]);

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid || opcode > 4'd8) |=> $stable(result) && $stable(status));

   p_br_signed_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (br_sel == 3'd4) |-> branch_taken == status[FB_S]);

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid     (op_valid),
   .opcode       (opcode),
   .opnd_a       (opnd_a),
   .opnd_b       (opnd_b),
   .br_sel       (br_sel),
   .result       (result),
   .status       (status),
   .branch_taken (branch_taken)
);

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] opcode = 4'd0;
   logic [7:0] opnd_a = 8'd0;
   logic [7:0] opnd_b = 8'd0;
   logic [2:0] br_sel = 3'd0;
   logic [7:0] result;
   logic [7:0] status;
   logic       branch_taken;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   flag_alu dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_valid     (op_valid),
      .opcode       (opcode),
      .opnd_a       (opnd_a),
      .opnd_b       (opnd_b),
      .br_sel       (br_sel),
      .result       (result),
      .status       (status),
      .branch_taken (branch_taken)
   );

   // {opcode, a, b, expected result, expected status}; status = {IE,0,H,S,V,N,Z,C}
   localparam int NVEC = 20;
   localparam logic [35:0] VEC [NVEC] = '{
      {4'd0, 8'hFF, 8'h01, 8'h00, 8'h23},  // R2 carry + half carry, R5 zero
      {4'd0, 8'h40, 8'h40, 8'h80, 8'h0C},  // R4 overflow, R5 N=1 V=1 S=0
      {4'd0, 8'h0A, 8'h06, 8'h10, 8'h20},  // R2 half carry set
      {4'd0, 8'h4A, 8'h24, 8'h6E, 8'h00},  // R2 half carry clear
      {4'd0, 8'h84, 8'h02, 8'h86, 8'h14},  // R5 N=1 V=0 S=1
      {4'd1, 8'h60, 8'h70, 8'hF0, 8'h15},  // R3 borrow, N
      {4'd3, 8'hF0, 8'h0F, 8'h00, 8'h03},  // R7 AND zero, C kept
      {4'd4, 8'h12, 8'h81, 8'h93, 8'h15},  // R7 OR
      {4'd2, 8'h05, 8'h05, 8'h93, 8'h02},  // R6 compare equal, result kept
      {4'd2, 8'h10, 8'h20, 8'h93, 8'h15},  // R6 compare lower
      {4'd1, 8'h10, 8'h01, 8'h0F, 8'h20},  // R3 half borrow
      {4'd5, 8'h7F, 8'h55, 8'h80, 8'h2C},  // R8 INC overflow, H kept
      {4'd6, 8'h80, 8'h55, 8'h7F, 8'h38},  // R8 DEC overflow
      {4'd8, 8'h80, 8'h55, 8'h80, 8'h0D},  // R10 NEG 0x80
      {4'd8, 8'h01, 8'h55, 8'hFF, 8'h35},  // R10 NEG 0x01
      {4'd7, 8'h3C, 8'h55, 8'h00, 8'h23},  // R9 clear, C H kept
      {4'd6, 8'h00, 8'h55, 8'hFF, 8'h35},  // R8 DEC wrap
      {4'd5, 8'hFF, 8'h55, 8'h00, 8'h23},  // R8 INC wrap, C kept
      {4'd1, 8'h80, 8'h01, 8'h7F, 8'h38},  // R4 subtract overflow
      {4'd4, 8'h00, 8'h00, 8'h00, 8'h22}   // R7 OR clears V
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic vld);
      @(negedge clk);
      opcode   = op;
      opnd_a   = a;
      opnd_b   = b;
      op_valid = vld;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic check_br(input string tag, input logic [2:0] sel, input logic exp);
      br_sel = sel;
      #1;
      check(tag, {7'd0, branch_taken}, {7'd0, exp});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset result", result, 8'h00);
      check("R1 reset status", status, 8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         run_op(VEC[i][35:32], VEC[i][31:24], VEC[i][23:16], 1'b1);
         check($sformatf("R2-vector %0d result", i), result, VEC[i][15:8]);
         check($sformatf("R5 vector %0d status", i), status, VEC[i][7:0]);
      end

      // R11: valid low leaves everything unchanged (state now 0x00 / 0x22)
      run_op(4'd0, 8'hFF, 8'h01, 1'b0);
      check("R11 idle result", result, 8'h00);
      check("R11 idle status", status, 8'h22);
      // R11: undefined opcode under valid
      run_op(4'd12, 8'h80, 8'h80, 1'b1);
      check("R11 undefined result", result, 8'h00);
      check("R11 undefined status", status, 8'h22);
      // R12: interrupt enable stays at reset value
      check("R12 ie bit", {7'd0, status[7]}, 8'h00);

      // R13 with status 0x22: Z=1, H=1
      check_br("R13 sel0 Z", 3'd0, 1'b1);
      check_br("R13 sel1 !Z", 3'd1, 1'b0);
      check_br("R13 sel3 !C", 3'd3, 1'b1);
      // R13 after compare 0x10 vs 0x20: C, N, S set (0x15)
      run_op(4'd2, 8'h10, 8'h20, 1'b1);
      check("R6 cmp status", status, 8'h15);
      check_br("R13 sel2 C", 3'd2, 1'b1);
      check_br("R13 sel3 !C", 3'd3, 1'b0);
      check_br("R13 sel4 S", 3'd4, 1'b1);
      check_br("R13 sel5 !S", 3'd5, 1'b0);
      // R13 after 0x40+0x40: N=1 V=1 S=0, signed test must follow S only
      run_op(4'd0, 8'h40, 8'h40, 1'b1);
      check("R4 status", status, 8'h0C);
      check_br("R13 sel4 S with N,V", 3'd4, 1'b0);
      check_br("R13 sel5 !S", 3'd5, 1'b1);
      check_br("R13 sel6 N", 3'd6, 1'b1);
      check_br("R13 sel7 V", 3'd7, 1'b1);
      check_br("R13 sel2 C", 3'd2, 1'b0);

      // R1: reset mid-run clears result and flags
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rereset result", result, 8'h00);
      check("R1 rereset status", status, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule